// File: doc/BRIEF.md
# Latched Address One-Hot Decoder

This block turns a small binary address into a set of active-low select lines. Exactly one line goes low for the address value, and only while the output gate is open. The address passes through a hold stage first. While the hold-enable input is low the stage is open and the selects follow the live address. Once hold-enable is high, the address last taken while it was low is kept, and later changes on the address pins have no effect.

Two gate inputs of opposite polarity control the outputs. The gate is open only when the active-low gate is low and the active-high gate is high. The gates act on the outputs alone and never touch the kept address. The hold stage samples on a free-running clock, so an address is taken at every clock edge where hold-enable is low.

A width parameter picks either a single 3-bit, 8-line decoder or a 4-bit, 16-line cascade of two such units. In the cascade the top address bit feeds the opposite-polarity gates of the two units. That bit therefore selects a half and is not held.

Top module: `latched_onehot_dec`

## Requirements
- R1: At most one bit of `sel_n` is low in any cycle.
- R2: While `hold` is 0 and the gate is open, `sel_n[i]` is 0 exactly for i equal to the live `addr`, and all other bits are 1.
- R3: At each clock edge where `hold` is 0, the address is taken into the hold stage. While `hold` is 1, the outputs decode the address taken at the last edge where `hold` was 0.
- R4: Changes on the held address bits while `hold` stays 1 leave `sel_n` unchanged.
- R5: Every bit of `sel_n` is 1 unless `gate_n` is 0 and `gate` is 1 together.
- R6: Toggling `gate_n` and `gate` never changes the kept address. When the gate reopens with `hold` still 1, the same line is selected as before.
- R7: A synchronous reset (`rst_n` low at a clock edge) clears the kept address to 0.
- R8: With `SEL_W` = 4, `sel_n` has 16 lines. The low half is decoded when `addr[3]` is 0 and the high half when it is 1. `addr[3]` is never held and always acts live. The low three bits are held as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the hold stage |
| rst_n | input | 1 | Synchronous active-low reset, clears the kept address |
| addr | input | SEL_W | Binary address |
| hold | input | 1 | 0: hold stage open, 1: kept address used |
| gate_n | input | 1 | Active-low output gate |
| gate | input | 1 | Active-high output gate |
| sel_n | output | 2**SEL_W | Active-low select lines, bit i for address i |

## Verification
Some properties are checked on every clock:
- the select lines never show more than one low bit;
- a closed gate forces every line high;
- with the stage open, the low line matches the live address;
- across consecutive held cycles under an open gate, the outputs do not move.

Some behaviours need an ordered run of cycles and are shown only by the bench's scenarios:
- which address is actually kept at the edge where hold rises;
- the reset value of the kept address;
- recovery of the kept address after the gates have been toggled;
- the half selection in the 16-line cascade.

// File: rtl/dec_pkg.sv
// Shared constants and types for the latched one-hot decoder.
package dec_pkg;
    localparam int BASE_W = 3;                  // address bits of one unit
    localparam int BASE_N = 1 << BASE_W;        // select lines of one unit
    typedef logic [BASE_W-1:0] base_addr_t;
endpackage

// File: rtl/addr_hold.sv
// Address hold stage. Takes `d` at every clock edge while `hold` is low and
// keeps it while `hold` is high. `eff` is the live address while the stage
// is open and the kept one otherwise. Assumes synchronous active-low reset.
module addr_hold #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] eff
);
    logic [W-1:0] kept_q;

    // Capture the address while open; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      kept_q <= '0;
        else if (!hold)  kept_q <= d;
    end

    // Open stage passes the live address straight through.
    always_comb eff = hold ? kept_q : d;
endmodule

// File: rtl/onehot_dec.sv
// Gated binary to active-low one-hot decoder. Purely combinational.
// Assumes that the gate is open only for gate_n == 0 and gate == 1.
module onehot_dec #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] a,
    input  logic         gate_n,
    input  logic         gate,
    output logic [N-1:0] y_n
);
    logic open_w;

    // Combine the two opposite-polarity gates.
    always_comb open_w = gate & ~gate_n;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Line i is low only when selected and gated open.
        assign y_n[i] = ~(open_w && (a == W'(i)));
    end
endmodule

// File: rtl/dec_unit.sv
// One decoder unit: an address hold stage followed by a gated decoder.
// The gates reach only the decoder, so they never affect the kept address.
module dec_unit
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  base_addr_t        addr,
    input  logic              hold,
    input  logic              gate_n,
    input  logic              gate,
    output logic [BASE_N-1:0] y_n
);
    base_addr_t eff_w;

    addr_hold #(.W(BASE_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .hold(hold), .d(addr), .eff(eff_w)
    );

    onehot_dec #(.W(BASE_W)) dec_i (
        .a(eff_w), .gate_n(gate_n), .gate(gate), .y_n(y_n)
    );
endmodule

// File: rtl/latched_onehot_dec.sv
// Top level. SEL_W = 3 gives a single unit. SEL_W = 4 gives two units whose
// gates are steered by addr[3], so the top bit picks a half and is not held.
// Assumes SEL_W is 3 or 4.
module latched_onehot_dec
    import dec_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] addr,
    input  logic             hold,
    input  logic             gate_n,
    input  logic             gate,
    output logic [OUT_N-1:0] sel_n
);
    if (SEL_W == BASE_W) begin : g_single
        dec_unit unit_i (
            .clk(clk), .rst_n(rst_n), .addr(addr[BASE_W-1:0]), .hold(hold),
            .gate_n(gate_n), .gate(gate), .y_n(sel_n)
        );
    end else begin : g_cascade
        logic top_w;
        logic lo_gate_n, hi_gate;

        // The top bit closes the low unit's active-low gate and opens the
        // high unit's active-high gate.
        always_comb begin
            top_w     = addr[SEL_W-1];
            lo_gate_n = gate_n | top_w;
            hi_gate   = gate & top_w;
        end

        dec_unit lo_i (
            .clk(clk), .rst_n(rst_n), .addr(addr[BASE_W-1:0]), .hold(hold),
            .gate_n(lo_gate_n), .gate(gate), .y_n(sel_n[BASE_N-1:0])
        );
        dec_unit hi_i (
            .clk(clk), .rst_n(rst_n), .addr(addr[BASE_W-1:0]), .hold(hold),
            .gate_n(gate_n), .gate(hi_gate), .y_n(sel_n[2*BASE_N-1:BASE_N])
        );
    end
endmodule

// File: rtl/dec_chk.sv
// Checker for latched_onehot_dec, attached with bind below.
module dec_chk #(
    parameter int SEL_W = 3,
    parameter int OUT_N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] addr,
    input logic             hold,
    input logic             gate_n,
    input logic             gate,
    input logic [OUT_N-1:0] sel_n
);
    logic seen_q;
    logic open_w;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    always_comb open_w = gate && !gate_n;

    // R1: never more than one line low.
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    // R5: a closed gate drives every line high.
    p_closed_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !open_w |-> (&sel_n));

    // R2: an open stage decodes the live address.
    p_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && open_w) |-> (sel_n == ~(OUT_N'(1) << addr)));

    // R4: held address, steady gate and steady live top bit keep outputs still.
    p_hold_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && hold && $past(hold) && open_w && $past(open_w) &&
         (SEL_W == 3 || $stable(addr[SEL_W-1]))) |-> $stable(sel_n));
endmodule

bind latched_onehot_dec dec_chk #(.SEL_W(SEL_W), .OUT_N(OUT_N)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .hold(hold),
    .gate_n(gate_n), .gate(gate), .sel_n(sel_n)
);

// File: tb/latched_onehot_dec_tb_top.sv
// Bench: a behavioural model of the kept address, compared on every clock
// against a default 8-line instance and a 16-line cascade.
module latched_onehot_dec_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        top_bit = 1'b0;
    logic        hold = 1'b0;
    logic        gate_n = 1'b0;
    logic        gate = 1'b1;
    logic [7:0]  sel8_n;
    logic [15:0] sel16_n;
    int          n_checks = 0;
    int          n_fail = 0;
    int          kept = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_onehot_dec dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .hold(hold),
        .gate_n(gate_n), .gate(gate), .sel_n(sel8_n)
    );

    latched_onehot_dec #(.SEL_W(4)) dut16_i (
        .clk(clk), .rst_n(rst_n), .addr({top_bit, addr}), .hold(hold),
        .gate_n(gate_n), .gate(gate), .sel_n(sel16_n)
    );

    // Reference model of the kept low address bits.
    always @(posedge clk) begin
        if (!rst_n)     kept <= 0;
        else if (!hold) kept <= int'(addr);
    end

    // Compare one output against its expected value.
    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then compare both instances with the model.
    task automatic cyc(string tag, logic h, logic gn, logic g, int a, logic tb);
        int          idx;
        logic        open;
        logic [15:0] e8;
        logic [15:0] e16;
        @(negedge clk);
        hold = h; gate_n = gn; gate = g; addr = 3'(a); top_bit = tb;
        #1;
        idx  = h ? kept : a;
        open = g && !gn;
        e8   = open ? {8'h00, ~(8'h01 << idx)} : 16'h00FF;
        e16  = open ? ~(16'h0001 << (idx + (tb ? 8 : 0))) : 16'hFFFF;
        check(tag, {8'h00, sel8_n}, e8);
        check({tag, " cascade"}, sel16_n, e16);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R7: reset with hold high. The live address 5 must not appear.
        cyc("R7 in reset", 1'b1, 1'b0, 1'b1, 5, 1'b0);
        cyc("R7 in reset", 1'b1, 1'b0, 1'b1, 5, 1'b0);
        rst_n = 1'b1;
        cyc("R7 cleared", 1'b1, 1'b0, 1'b1, 5, 1'b0);
        cyc("R7 cleared", 1'b1, 1'b0, 1'b1, 3, 1'b0);
        // R2 R5 R1: every address under every gate combination, stage open.
        for (int a = 0; a < 8; a++)
            for (int gc = 0; gc < 4; gc++)
                cyc("R2 R5 sweep", 1'b0, gc[0], gc[1], a, 1'b0);
        // R3: 6 is taken and kept when hold rises, even though 2 is live.
        cyc("R3 open", 1'b0, 1'b0, 1'b1, 6, 1'b0);
        cyc("R3 hold rise", 1'b1, 1'b0, 1'b1, 2, 1'b0);
        // R4: live address changes while held.
        for (int a = 0; a < 8; a++)
            cyc("R4 ignore", 1'b1, 1'b0, 1'b1, 7 - a, 1'b0);
        // R6: gate toggles while held, then reopen.
        cyc("R6 closed n", 1'b1, 1'b1, 1'b1, 1, 1'b0);
        cyc("R6 closed p", 1'b1, 1'b0, 1'b0, 4, 1'b0);
        cyc("R6 both off", 1'b1, 1'b1, 1'b0, 0, 1'b0);
        cyc("R6 reopen", 1'b1, 1'b0, 1'b1, 3, 1'b0);
        // R8: cascade with the top bit live, stage open.
        for (int a = 0; a < 16; a++)
            cyc("R8 sweep", 1'b0, 1'b0, 1'b1, a % 8, a >= 8);
        // R8: while held, flipping the top bit moves between halves.
        cyc("R8 take", 1'b0, 1'b0, 1'b1, 5, 1'b0);
        cyc("R8 held lo", 1'b1, 1'b0, 1'b1, 1, 1'b0);
        cyc("R8 held hi", 1'b1, 1'b0, 1'b1, 2, 1'b1);
        cyc("R8 held lo", 1'b1, 1'b0, 1'b1, 7, 1'b0);
        // R7: reset again while held clears the kept address.
        rst_n = 1'b0;
        cyc("R7 reset2", 1'b1, 1'b0, 1'b1, 4, 1'b1);
        rst_n = 1'b1;
        cyc("R7 after2", 1'b1, 1'b0, 1'b1, 4, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule